// File: doc/BRIEF.md
# SPI Slave Control and Interrupt Register File

This block is the device-side register file behind a SPI slave front end. The front end decodes serial commands into a simple byte-wide bus with separate read and write strobes, a 4-bit byte address and 8-bit data. The bus carries transfer-format configuration, status-reporting options, a 16-bit pending-interrupt register, a 16-bit interrupt enable register, a read-only 32-bit status word and a read-only function-1 information word.

Hardware event inputs set the pending interrupt bits. The host clears them by writing ones. The block drives an interrupt pin from the enabled pending bits, and the pin's active level is programmable. A host wake-up write passes through a small two-state sequencer. The sequencer raises the function-2 interrupt to acknowledge that the device is awake. In state `WK_IDLE`, a write with bit 7 set at address 0x0 moves the sequencer to `WK_RAISE`. `WK_RAISE` presents the function-2 event for one cycle. It then returns to `WK_IDLE`, or stays in `WK_RAISE` if a new wake write arrives in that cycle.

Top module: `spi_ctrl_regs`

## Requirements
- R1: After reset, address 0x0 reads 0x30, 0x2 reads 0x01, 0x4 and 0x5 read 0x00, 0x6 reads 0xE7, 0x7 reads 0xE0, and irq_o is 0.
- R2: Address 0x0 bit 0 is the 32-bit word select, bit 1 big-endian, bit 4 high-speed and bit 5 interrupt active-high. These bits are writable, readable and drive their outputs from the cycle after the write. Bits 2, 3, 6 and 7 of address 0x0 read as 0.
- R3: Writing 1 to bit 7 of address 0x0 sets pending bit 14 (address 0x5 bit 6) two clock edges after the write edge.
- R4: Address 0x2 bit 0 (status enable, drives stat_en_o) and bit 1 (interrupt-with-status, drives stat_irq_o) are writable. Its other bits read 0.
- R5: A high evt_i bit sets the matching pending bit at the next edge, but only for implemented bits 0, 1, 2, 5, 6, 7, 13, 14 and 15 (mask 0xE0E7). Other pending bits always read 0.
- R6: Writing 1 to a pending bit at 0x4 (bits 7:0) or 0x5 (bits 15:8) clears it. Writing 0 leaves it unchanged.
- R7: An event that sets a pending bit in the same cycle as a host clear of that bit wins, and the bit stays set.
- R8: The enable register is fully read/write, with bits 7:0 at 0x6 and bits 15:8 at 0x7.
- R9: At every edge irq_o takes the OR of (pending AND enable), inverted when the active-high bit is 0. The value uses the register state from before that edge.
- R10: Addresses 0x8 to 0xB return status_i bytes 0 to 3 (least significant first), and writes there are ignored.
- R11: Address 0xC/0xD read a 16-bit word with bit 0 = 1 (enabled), bit 1 = f1_ready_i and bits 13:2 = max packet size (default 0x40). Host writes are ignored.
- R12: Addresses 0x1, 0x3, 0xE and 0xF read 0, and writes there change no register.
- R13: rdata_o is loaded at an edge where rd_en_i is high and holds its value at all other edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Byte write strobe |
| rd_en_i | input | 1 | Byte read strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| evt_i | input | IRQ_W | Hardware interrupt events, one per pending bit |
| status_i | input | STAT_W | Live status word |
| f1_ready_i | input | 1 | Function 1 ready for data |
| word32_o | output | 1 | 32-bit word length selected |
| big_endian_o | output | 1 | Big-endian byte order selected |
| high_speed_o | output | 1 | High-speed sampling mode |
| stat_en_o | output | 1 | Send status after each transfer |
| stat_irq_o | output | 1 | Interrupt even when status is sent |
| irq_o | output | 1 | Interrupt pin level |

## Verification
A corrupted pending or enable bit reaches irq_o at the very next edge. It also shows on the next read of 0x4 through 0x7, one edge after the strobe. A wake sequencer stuck in `WK_RAISE` keeps re-setting pending bit 14 after the host clears it, so the following read of 0x5 exposes it. A reference model updated on every edge compares every output in every cycle, so a divergence is reported in the cycle it first reaches a pin.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;

    localparam int BYTE_W = 8;

    localparam logic [3:0] A_CFG    = 4'h0;
    localparam logic [3:0] A_STOPT  = 4'h2;
    localparam logic [3:0] A_IRQ_LO = 4'h4;
    localparam logic [3:0] A_EN_LO  = 4'h6;
    localparam logic [3:0] A_STAT0  = 4'h8;
    localparam logic [3:0] A_F1_LO  = 4'hC;

    localparam int CFG_WAKE_BIT = 7;

    typedef enum logic {
        WK_IDLE  = 1'b0,
        WK_RAISE = 1'b1
    } wake_state_t;

    typedef struct packed {
        logic irq_active_high;
        logic high_speed;
        logic big_endian;
        logic word32;
    } bus_cfg_t;

endpackage

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
    import spi_regs_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [BYTE_W-1:0]    wdata_i,
    output bus_cfg_t             cfg_o,
    output logic                 stat_en_o,
    output logic                 stat_irq_o,
    output logic                 wake_evt_o
);

    logic        hit_cfg;
    logic        hit_stopt;
    logic        wake_wr;
    bus_cfg_t    cfg_q;
    logic        sen_q;
    logic        sirq_q;
    wake_state_t wk_state;
    wake_state_t wk_next;

    assign hit_cfg   = wr_en_i && (addr_i == ADDR_W'(A_CFG));
    assign hit_stopt = wr_en_i && (addr_i == ADDR_W'(A_STOPT));
    assign wake_wr   = hit_cfg && wdata_i[CFG_WAKE_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.word32          <= 1'b0;
            cfg_q.big_endian      <= 1'b0;
            cfg_q.high_speed      <= 1'b1;
            cfg_q.irq_active_high <= 1'b1;
        end else if (hit_cfg) begin
            cfg_q.word32          <= wdata_i[0];
            cfg_q.big_endian      <= wdata_i[1];
            cfg_q.high_speed      <= wdata_i[4];
            cfg_q.irq_active_high <= wdata_i[5];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sen_q  <= 1'b1;
            sirq_q <= 1'b0;
        end else if (hit_stopt) begin
            sen_q  <= wdata_i[0];
            sirq_q <= wdata_i[1];
        end
    end

    // wake sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wk_state <= WK_IDLE;
        end else begin
            wk_state <= wk_next;
        end
    end

    // wake sequencer: transitions
    always_comb begin
        wk_next = wk_state;
        unique case (wk_state)
            WK_IDLE:  wk_next = wake_wr ? WK_RAISE : WK_IDLE;
            WK_RAISE: wk_next = wake_wr ? WK_RAISE : WK_IDLE;
            default:  wk_next = WK_IDLE;
        endcase
    end

    // wake sequencer: outputs
    always_comb begin
        wake_evt_o = 1'b0;
        unique case (wk_state)
            WK_IDLE:  wake_evt_o = 1'b0;
            WK_RAISE: wake_evt_o = 1'b1;
            default:  wake_evt_o = 1'b0;
        endcase
    end

    assign cfg_o      = cfg_q;
    assign stat_en_o  = sen_q;
    assign stat_irq_o = sirq_q;

    p_wake_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wake_wr |=> wake_evt_o)
        else $error("p_wake_seq_r3");

    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_cfg |=> $stable(cfg_o))
        else $error("p_cfg_hold_r2");

endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
    import spi_regs_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter int                IRQ_W    = 16,
    parameter logic [IRQ_W-1:0]  IRQ_MASK = 16'hE0E7,
    parameter logic [IRQ_W-1:0]  EN_RST   = 16'hE0E7,
    parameter int                WAKE_BIT = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [BYTE_W-1:0]    wdata_i,
    input  logic [IRQ_W-1:0]     evt_i,
    input  logic                 wake_evt_i,
    input  logic                 active_high_i,
    output logic [IRQ_W-1:0]     pend_o,
    output logic [IRQ_W-1:0]     en_o,
    output logic                 irq_o
);

    localparam int NB = IRQ_W / BYTE_W;

    logic [IRQ_W-1:0] pend_q;
    logic [IRQ_W-1:0] set_v;
    logic [IRQ_W-1:0] clr_v;
    logic [IRQ_W-1:0] wake_v;
    logic             any_v;
    logic             irq_q;

    always_comb begin
        wake_v           = '0;
        wake_v[WAKE_BIT] = wake_evt_i;
    end

    assign set_v = (evt_i | wake_v) & IRQ_MASK;

    always_comb begin
        clr_v = '0;
        for (int b = 0; b < NB; b++) begin
            if (wr_en_i && (addr_i == ADDR_W'(A_IRQ_LO) + ADDR_W'(b))) begin
                clr_v[BYTE_W*b +: BYTE_W] = wdata_i;
            end
        end
        clr_v = clr_v & IRQ_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_v) | set_v;
        end
    end

    genvar gb;
    generate
        for (gb = 0; gb < NB; gb++) begin : g_en_lane
            logic [BYTE_W-1:0] lane_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lane_q <= EN_RST[BYTE_W*gb +: BYTE_W];
                end else if (wr_en_i && (addr_i == ADDR_W'(A_EN_LO) + ADDR_W'(gb))) begin
                    lane_q <= wdata_i;
                end
            end
            assign en_o[BYTE_W*gb +: BYTE_W] = lane_q;
        end
    endgenerate

    assign any_v = |(pend_q & en_o);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= active_high_i ? any_v : ~any_v;
        end
    end

    assign pend_o = pend_q;
    assign irq_o  = irq_q;

    p_unimpl_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((pend_q & ~IRQ_MASK) == '0))
        else $error("p_unimpl_zero_r5");

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_v & ~set_v)) |=> ((pend_q & $past(clr_v & ~set_v)) == '0))
        else $error("p_clear_r6");

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_v) |=> ((pend_q & $past(set_v)) == $past(set_v)))
        else $error("p_set_wins_r7");

    p_wake_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt_i |=> pend_q[WAKE_BIT])
        else $error("p_wake_pend_r3");

endmodule

// File: rtl/spi_rd_mux.sv
module spi_rd_mux
    import spi_regs_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int IRQ_W  = 16,
    parameter int STAT_W = 32,
    parameter int F1_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  bus_cfg_t             cfg_i,
    input  logic                 stat_en_i,
    input  logic                 stat_irq_i,
    input  logic [IRQ_W-1:0]     pend_i,
    input  logic [IRQ_W-1:0]     en_i,
    input  logic [STAT_W-1:0]    status_i,
    input  logic [F1_W-1:0]      f1_info_i,
    output logic [BYTE_W-1:0]    rdata_o
);

    localparam int IRQ_NB  = IRQ_W / BYTE_W;
    localparam int STAT_NB = STAT_W / BYTE_W;
    localparam int F1_NB   = F1_W / BYTE_W;

    logic [BYTE_W-1:0] sel_v;
    logic [BYTE_W-1:0] rdata_q;

    always_comb begin
        sel_v = '0;
        if (addr_i == ADDR_W'(A_CFG)) begin
            sel_v = {2'b00, cfg_i.irq_active_high, cfg_i.high_speed,
                     2'b00, cfg_i.big_endian, cfg_i.word32};
        end
        if (addr_i == ADDR_W'(A_STOPT)) begin
            sel_v = {6'b000000, stat_irq_i, stat_en_i};
        end
        for (int b = 0; b < IRQ_NB; b++) begin
            if (addr_i == ADDR_W'(A_IRQ_LO) + ADDR_W'(b)) begin
                sel_v = pend_i[BYTE_W*b +: BYTE_W];
            end
            if (addr_i == ADDR_W'(A_EN_LO) + ADDR_W'(b)) begin
                sel_v = en_i[BYTE_W*b +: BYTE_W];
            end
        end
        for (int b = 0; b < STAT_NB; b++) begin
            if (addr_i == ADDR_W'(A_STAT0) + ADDR_W'(b)) begin
                sel_v = status_i[BYTE_W*b +: BYTE_W];
            end
        end
        for (int b = 0; b < F1_NB; b++) begin
            if (addr_i == ADDR_W'(A_F1_LO) + ADDR_W'(b)) begin
                sel_v = f1_info_i[BYTE_W*b +: BYTE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en_i) begin
            rdata_q <= sel_v;
        end
    end

    assign rdata_o = rdata_q;

    p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_o))
        else $error("p_rdata_hold_r13");

endmodule

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs
    import spi_regs_pkg::*;
#(
    parameter int                ADDR_W     = 4,
    parameter int                IRQ_W      = 16,
    parameter int                STAT_W     = 32,
    parameter int                F1_PKT_W   = 12,
    parameter logic [F1_PKT_W-1:0] F1_MAX_PKT = 12'h040,
    parameter logic [IRQ_W-1:0]  IRQ_MASK   = 16'hE0E7,
    parameter logic [IRQ_W-1:0]  EN_RST     = 16'hE0E7,
    parameter int                WAKE_BIT   = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic                 rd_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [7:0]           wdata_i,
    output logic [7:0]           rdata_o,
    input  logic [IRQ_W-1:0]     evt_i,
    input  logic [STAT_W-1:0]    status_i,
    input  logic                 f1_ready_i,
    output logic                 word32_o,
    output logic                 big_endian_o,
    output logic                 high_speed_o,
    output logic                 stat_en_o,
    output logic                 stat_irq_o,
    output logic                 irq_o
);

    localparam int F1_W   = 16;
    localparam int F1_PAD = F1_W - F1_PKT_W - 2;

    bus_cfg_t          cfg_w;
    logic              wake_evt_w;
    logic [IRQ_W-1:0]  pend_w;
    logic [IRQ_W-1:0]  en_w;
    logic [F1_W-1:0]   f1_info_w;

    assign f1_info_w = {{F1_PAD{1'b0}}, F1_MAX_PKT, f1_ready_i, 1'b1};

    spi_cfg_regs #(
        .ADDR_W (ADDR_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .cfg_o      (cfg_w),
        .stat_en_o  (stat_en_o),
        .stat_irq_o (stat_irq_o),
        .wake_evt_o (wake_evt_w)
    );

    spi_irq_ctrl #(
        .ADDR_W   (ADDR_W),
        .IRQ_W    (IRQ_W),
        .IRQ_MASK (IRQ_MASK),
        .EN_RST   (EN_RST),
        .WAKE_BIT (WAKE_BIT)
    ) u_irq (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (wr_en_i),
        .addr_i        (addr_i),
        .wdata_i       (wdata_i),
        .evt_i         (evt_i),
        .wake_evt_i    (wake_evt_w),
        .active_high_i (cfg_w.irq_active_high),
        .pend_o        (pend_w),
        .en_o          (en_w),
        .irq_o         (irq_o)
    );

    spi_rd_mux #(
        .ADDR_W (ADDR_W),
        .IRQ_W  (IRQ_W),
        .STAT_W (STAT_W),
        .F1_W   (F1_W)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en_i    (rd_en_i),
        .addr_i     (addr_i),
        .cfg_i      (cfg_w),
        .stat_en_i  (stat_en_o),
        .stat_irq_i (stat_irq_o),
        .pend_i     (pend_w),
        .en_i       (en_w),
        .status_i   (status_i),
        .f1_info_i  (f1_info_w),
        .rdata_o    (rdata_o)
    );

    assign word32_o     = cfg_w.word32;
    assign big_endian_o = cfg_w.big_endian;
    assign high_speed_o = cfg_w.high_speed;

    p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == ($past(cfg_w.irq_active_high) ?
                             (|$past(pend_w & en_w)) : !(|$past(pend_w & en_w)))))
        else $error("p_irq_level_r9");

endmodule

// File: tb/sim_spi_ctrl_regs.sv
module sim_spi_ctrl_regs;

    localparam logic [15:0] MASK = 16'hE0E7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [15:0] evt = '0;
    logic [31:0] status = '0;
    logic        f1_ready = 1'b0;
    logic        word32, big_endian, high_speed, stat_en, stat_irq, irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    bit live = 1'b0;

    always #2 clk = ~clk;

    spi_ctrl_regs u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en),
        .rd_en_i      (rd_en),
        .addr_i       (addr),
        .wdata_i      (wdata),
        .rdata_o      (rdata),
        .evt_i        (evt),
        .status_i     (status),
        .f1_ready_i   (f1_ready),
        .word32_o     (word32),
        .big_endian_o (big_endian),
        .high_speed_o (high_speed),
        .stat_en_o    (stat_en),
        .stat_irq_o   (stat_irq),
        .irq_o        (irq)
    );

    // behavioural reference model
    bit          m_w32, m_be, m_hs, m_pol, m_sen, m_sirq, m_wk, m_irq;
    logic [15:0] m_pend, m_en;
    logic [7:0]  m_rd;

    function automatic logic [7:0] mread(input logic [3:0] a);
        logic [15:0] f1;
        f1 = (16'h0040 << 2) | {14'd0, f1_ready, 1'b1};
        case (a)
            4'h0: return {2'b00, m_pol, m_hs, 2'b00, m_be, m_w32};
            4'h2: return {6'd0, m_sirq, m_sen};
            4'h4: return m_pend[7:0];
            4'h5: return m_pend[15:8];
            4'h6: return m_en[7:0];
            4'h7: return m_en[15:8];
            4'h8: return status[7:0];
            4'h9: return status[15:8];
            4'hA: return status[23:16];
            4'hB: return status[31:24];
            4'hC: return f1[7:0];
            4'hD: return f1[15:8];
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_w32 = 0; m_be = 0; m_hs = 1; m_pol = 1; m_sen = 1; m_sirq = 0;
            m_wk = 0; m_irq = 0; m_pend = '0; m_en = 16'hE0E7; m_rd = '0;
        end else begin
            logic [7:0]  rv;
            logic [15:0] setm, clrm;
            bit          irqn, wk_n, anyv;
            rv   = mread(addr);
            anyv = |(m_pend & m_en);
            irqn = m_pol ? anyv : !anyv;
            setm = evt;
            if (m_wk) setm[14] = 1'b1;
            setm = setm & MASK;
            clrm = '0;
            wk_n = 0;
            if (wr_en) begin
                case (addr)
                    4'h0: begin
                        m_w32 = wdata[0]; m_be = wdata[1];
                        m_hs = wdata[4];  m_pol = wdata[5];
                        wk_n = wdata[7];
                    end
                    4'h2: begin m_sen = wdata[0]; m_sirq = wdata[1]; end
                    4'h4: clrm[7:0]  = wdata;
                    4'h5: clrm[15:8] = wdata;
                    4'h6: m_en[7:0]  = wdata;
                    4'h7: m_en[15:8] = wdata;
                    default: ;
                endcase
            end
            m_pend = (m_pend & ~(clrm & MASK)) | setm;
            if (rd_en) m_rd = rv;
            m_irq = irqn;
            m_wk  = wk_n;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (live && rst_n) begin
            chk(rdata, m_rd, "R13 model rdata");
            chk(irq, m_irq, "R9 model irq");
            chk({word32, big_endian, high_speed}, {m_w32, m_be, m_hs}, "R2 model cfg");
            chk({stat_en, stat_irq}, {m_sen, m_sirq}, "R4 model status options");
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        chk(rdata, exp, tag);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        live  = 1'b1;
        idle(1);

        // R1 reset state
        rd(4'h0, 8'h30, "R1 cfg reset");
        rd(4'h2, 8'h01, "R1 status options reset");
        rd(4'h4, 8'h00, "R1 pend lo reset");
        rd(4'h5, 8'h00, "R1 pend hi reset");
        rd(4'h6, 8'hE7, "R1 enable lo reset");
        rd(4'h7, 8'hE0, "R1 enable hi reset");
        chk(irq, 1'b0, "R1 irq reset");

        // R2 configuration bits, R9 polarity with nothing pending
        wr(4'h0, 8'h03);
        rd(4'h0, 8'h03, "R2 cfg readback");
        chk({word32, big_endian, high_speed}, 3'b110, "R2 cfg outputs");
        chk(irq, 1'b1, "R9 active-low idle level");
        wr(4'h0, 8'h4C);
        rd(4'h0, 8'h00, "R2 unused cfg bits read zero");
        wr(4'h0, 8'h30);

        // R3 wake-up raises pending bit 14
        wr(4'h0, 8'hB0);
        idle(1);
        rd(4'h5, 8'h40, "R3 wake sets pending bit 14");
        rd(4'h0, 8'h30, "R3 wake bit reads zero");
        chk(irq, 1'b1, "R9 wake interrupt on pin");
        wr(4'h5, 8'h40);
        idle(1);
        rd(4'h5, 8'h00, "R6 clear wake interrupt");
        chk(irq, 1'b0, "R9 pin released");

        // R4 status options
        wr(4'h2, 8'h02);
        rd(4'h2, 8'h02, "R4 options readback");
        chk({stat_en, stat_irq}, 2'b01, "R4 options outputs");
        wr(4'h2, 8'hFD);
        rd(4'h2, 8'h01, "R4 upper bits ignored");

        // R5 events and mask
        evt = 16'hFFFF;
        @(negedge clk);
        evt = '0;
        rd(4'h4, 8'hE7, "R5 pend lo after events");
        rd(4'h5, 8'hE0, "R5 pend hi after events");

        // R6 write-one-to-clear
        wr(4'h4, 8'h00);
        rd(4'h4, 8'hE7, "R6 zero write no effect");
        wr(4'h4, 8'h21);
        rd(4'h4, 8'hC6, "R6 selective clear");

        // R7 event beats simultaneous clear
        evt = 16'h0001;
        wr(4'h4, 8'h03);
        evt = '0;
        rd(4'h4, 8'hC5, "R7 set wins over clear");

        // R8 enable register
        wr(4'h6, 8'h00);
        wr(4'h7, 8'h00);
        rd(4'h6, 8'h00, "R8 enable lo write");
        rd(4'h7, 8'h00, "R8 enable hi write");
        chk(irq, 1'b0, "R9 all masked");
        wr(4'h7, 8'h80);
        rd(4'h7, 8'h80, "R8 enable bit 15");
        chk(irq, 1'b1, "R9 enabled pending asserts");
        wr(4'h0, 8'h10);
        idle(1);
        chk(irq, 1'b0, "R9 active-low asserted level");
        wr(4'h0, 8'h30);

        // R10 status word
        status = 32'h89AB_CDEF;
        rd(4'h8, 8'hEF, "R10 status byte 0");
        rd(4'h9, 8'hCD, "R10 status byte 1");
        rd(4'hA, 8'hAB, "R10 status byte 2");
        rd(4'hB, 8'h89, "R10 status byte 3");
        wr(4'h8, 8'h00);
        rd(4'h8, 8'hEF, "R10 write ignored");

        // R11 function-1 info
        rd(4'hC, 8'h01, "R11 info lo not ready");
        rd(4'hD, 8'h01, "R11 info hi");
        f1_ready = 1'b1;
        rd(4'hC, 8'h03, "R11 info lo ready");
        wr(4'hC, 8'h00);
        wr(4'hD, 8'hFF);
        rd(4'hC, 8'h03, "R11 write ignored lo");
        rd(4'hD, 8'h01, "R11 write ignored hi");

        // R12 reserved addresses
        wr(4'h1, 8'hFF);
        wr(4'h3, 8'hFF);
        wr(4'hE, 8'hFF);
        rd(4'h1, 8'h00, "R12 addr 1 zero");
        rd(4'h3, 8'h00, "R12 addr 3 zero");
        rd(4'hE, 8'h00, "R12 addr E zero");
        rd(4'h0, 8'h30, "R12 cfg untouched");
        rd(4'h2, 8'h01, "R12 options untouched");

        // R13 read data holds without strobe
        rd(4'h0, 8'h30, "R13 load");
        addr = 4'h6;
        idle(3);
        chk(rdata, 8'h30, "R13 hold without strobe");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule